// File: doc/BRIEF.md
# Parity Bus Transceiver with Error Flag

This block moves a byte between two buses. On the A side it has a plain data bus. On the B side it has a data bus plus one extra parity line. Two active-low drive controls select the direction of transfer. In the A-to-B direction the block drives A's data onto B and adds a parity bit, so the nine B-side bits carry an odd number of ones. In the B-to-A direction it drives B's data onto A and checks the nine incoming bits. An even count of ones is reported as an error on an active-low error output.

When both drive controls are low, the block runs a diagnostic mode. It drives A onto B with the parity bit inverted, which forces an error that the checker sees. When both controls are high, neither bus is driven, but the checker keeps watching the B inputs. Each bus is modelled as separate input, output and output-enable signals.

The error output comes from a small flag controller with two states.
- State FLAG_CLEAN means no error is stored. State FLAG_FAULT means an error is stored.
- Pass: with hold low, the output follows the live check.
- Sample: with hold low, each rising clock edge loads the live check into the state. The transition is to FLAG_CLEAN on a good check and to FLAG_FAULT on a bad one.
- Store: with hold high, the state and the output stay put.
- Clear: a low clear input overrides everything. It forces the output high and moves the state to FLAG_CLEAN.

The transfer direction is decoded into four modes:
- MODE_A2B: A drives B, with normal parity.
- MODE_B2A: B drives A, and the incoming bits are checked.
- MODE_DIAG: A drives B, with inverted parity.
- MODE_ISOL: no bus is driven.

Top module: `pbus_xcvr`

## Requirements
- R1: With a_drive_n=1 and b_drive_n=0 (MODE_A2B), the outputs are b_out=a_in, b_oe=1, par_oe=1 and a_oe=0. par_out is 1 exactly when a_in holds an even number of ones.
- R2: With a_drive_n=0 and b_drive_n=1 (MODE_B2A), the outputs are a_out=b_in, a_oe=1, b_oe=0 and par_oe=0. b_out and par_out are 0.
- R3: With both drive inputs at 0 (MODE_DIAG), the outputs are b_out=a_in, b_oe=1, par_oe=1 and a_oe=0. par_out is 1 exactly when a_in holds an odd number of ones, so the nine driven bits carry an even count.
- R4: With both drive inputs at 1 (MODE_ISOL), all three enables are 0 and a_out, b_out and par_out are 0. Whenever a bus output is not enabled, it reads 0.
- R5: The check result is 1 (good) when the nine B-side bits hold an odd number of ones. In MODE_A2B and MODE_DIAG the B-side bits are the driven b_out and par_out; otherwise they are b_in and par_in. With flag_hold=0 and flag_clr_n=1, err_n equals the check result in the same cycle.
- R6: While flag_clr_n=0, err_n is 1 whatever flag_hold and the check result are. A clock edge with flag_clr_n=0 sets the stored flag to FLAG_CLEAN.
- R7: With flag_hold=1 and flag_clr_n=1, err_n shows the stored flag: 1 for FLAG_CLEAN, 0 for FLAG_FAULT. Changes in the check result do not affect it.
- R8: At each rising clock edge with flag_hold=0 and flag_clr_n=1, the stored flag takes the check result. Raising flag_hold therefore keeps the last sampled value.
- R9: Reset (rst_n=0, asynchronous) puts the stored flag in FLAG_CLEAN, so err_n reads 1 under hold after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the stored error flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_drive_n | input | 1 | Active-low enable for driving the A bus |
| b_drive_n | input | 1 | Active-low enable for driving the B bus and parity line |
| flag_hold | input | 1 | High holds the stored flag; low passes and samples |
| flag_clr_n | input | 1 | Active-low clear of the error flag |
| a_in | input | WIDTH | A bus input |
| a_out | output | WIDTH | A bus output value |
| a_oe | output | 1 | A bus output enable |
| b_in | input | WIDTH | B bus input |
| b_out | output | WIDTH | B bus output value |
| b_oe | output | 1 | B bus output enable |
| par_in | input | 1 | Parity line input |
| par_out | output | 1 | Parity line output value |
| par_oe | output | 1 | Parity line output enable |
| err_n | output | 1 | Active-low parity error flag |

## Verification
Some properties are checked by assertions on every cycle:
- The two bus enables never overlap.
- The driven B side has odd weight in MODE_A2B and even weight in MODE_DIAG.
- MODE_ISOL drives nothing.
- The stored flag holds under hold, clears after a clear edge, and tracks the previous check result on a sample edge.

Other behaviour only the bench scenarios can show. These are the exact data routing in every mode over all 256 data values, with random parity-line corruption, and the same-cycle pass path. They also include the held value surviving check changes across several cycles, and the reset value.

// File: rtl/pbx_pkg.sv
package pbx_pkg;
    // Transfer mode decoded from the two active-low drive controls
    typedef enum logic [1:0] {
        MODE_A2B  = 2'd0,
        MODE_B2A  = 2'd1,
        MODE_DIAG = 2'd2,
        MODE_ISOL = 2'd3
    } xfer_mode_t;

    // Stored error-flag state
    typedef enum logic {
        FLAG_CLEAN = 1'b0,
        FLAG_FAULT = 1'b1
    } flag_state_t;
endpackage

// File: rtl/pbx_mode_dec.sv
module pbx_mode_dec
    import pbx_pkg::*;
(
    input  logic       a_drive_n,
    input  logic       b_drive_n,
    output xfer_mode_t mode,
    output logic       a_en,
    output logic       b_en
);
    always_comb begin
        unique case ({a_drive_n, b_drive_n})
            2'b10:   mode = MODE_A2B;
            2'b01:   mode = MODE_B2A;
            2'b00:   mode = MODE_DIAG;
            default: mode = MODE_ISOL;
        endcase
    end

    always_comb begin
        a_en = 1'b0;
        b_en = 1'b0;
        unique case (mode)
            MODE_A2B:  b_en = 1'b1;
            MODE_DIAG: b_en = 1'b1;
            MODE_B2A:  a_en = 1'b1;
            MODE_ISOL: ;
        endcase
    end
endmodule

// File: rtl/pbx_par_unit.sv
module pbx_par_unit
    import pbx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  xfer_mode_t       mode,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             par_in,
    output logic             gen_par,
    output logic             chk_ok
);
    localparam int SIDE_W = WIDTH + 1;

    logic             a_odd;
    logic [SIDE_W-1:0] side_bits;

    assign a_odd = ^a_in;

    // Normal mode makes the nine bits odd; diagnostic mode inverts it
    always_comb begin
        unique case (mode)
            MODE_DIAG: gen_par = a_odd;
            default:   gen_par = ~a_odd;
        endcase
    end

    // The checker looks at whatever is on the B side
    always_comb begin
        unique case (mode)
            MODE_A2B, MODE_DIAG: side_bits = {a_in, gen_par};
            default:             side_bits = {b_in, par_in};
        endcase
    end

    assign chk_ok = ^side_bits;
endmodule

// File: rtl/pbx_err_flag.sv
module pbx_err_flag
    import pbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flag_hold,
    input  logic flag_clr_n,
    input  logic chk_ok,
    output logic err_n
);
    flag_state_t flag_q;
    flag_state_t flag_d;

    // Next state: clear > store > sample
    always_comb begin
        flag_d = flag_q;
        if (!flag_clr_n)
            flag_d = FLAG_CLEAN;
        else if (!flag_hold)
            flag_d = chk_ok ? FLAG_CLEAN : FLAG_FAULT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= FLAG_CLEAN;
        else
            flag_q <= flag_d;
    end

    // Output: clear forces high, pass shows live check, store shows state
    always_comb begin
        if (!flag_clr_n)
            err_n = 1'b1;
        else if (!flag_hold)
            err_n = chk_ok;
        else
            err_n = (flag_q == FLAG_CLEAN);
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr_n |=> flag_q == FLAG_CLEAN); // R6

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_hold && flag_clr_n) |=> $stable(flag_q)); // R7

    AST_SAMPLE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_hold && flag_clr_n) |=> (flag_q == ($past(chk_ok) ? FLAG_CLEAN : FLAG_FAULT))); // R8
endmodule

// File: rtl/pbus_xcvr.sv
module pbus_xcvr
    import pbx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_drive_n,
    input  logic             b_drive_n,
    input  logic             flag_hold,
    input  logic             flag_clr_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             par_in,
    output logic             par_out,
    output logic             par_oe,
    output logic             err_n
);
    xfer_mode_t mode;
    logic       a_en;
    logic       b_en;
    logic       gen_par;
    logic       chk_ok;

    pbx_mode_dec u_dec (
        .a_drive_n (a_drive_n),
        .b_drive_n (b_drive_n),
        .mode      (mode),
        .a_en      (a_en),
        .b_en      (b_en)
    );

    pbx_par_unit #(.WIDTH(WIDTH)) u_par (
        .mode    (mode),
        .a_in    (a_in),
        .b_in    (b_in),
        .par_in  (par_in),
        .gen_par (gen_par),
        .chk_ok  (chk_ok)
    );

    pbx_err_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_hold  (flag_hold),
        .flag_clr_n (flag_clr_n),
        .chk_ok     (chk_ok),
        .err_n      (err_n)
    );

    assign a_out   = a_en ? b_in : '0;
    assign a_oe    = a_en;
    assign b_out   = b_en ? a_in : '0;
    assign b_oe    = b_en;
    assign par_out = b_en ? gen_par : 1'b0;
    assign par_oe  = b_en;

    AST_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe)); // R4

    AST_ISOL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drive_n && b_drive_n) |-> (!a_oe && !b_oe && !par_oe)); // R4

    AST_TX_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drive_n && !b_drive_n) |-> (^{b_out, par_out})); // R1

    AST_DIAG_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_drive_n && !b_drive_n) |-> !(^{b_out, par_out})); // R3
endmodule

// File: tb/pbus_xcvr_test.sv
module pbus_xcvr_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         a_drive_n, b_drive_n, flag_hold, flag_clr_n;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_oe, b_oe, par_in, par_out, par_oe, err_n;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    pbus_xcvr #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .a_drive_n(a_drive_n), .b_drive_n(b_drive_n),
        .flag_hold(flag_hold), .flag_clr_n(flag_clr_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .par_in(par_in), .par_out(par_out), .par_oe(par_oe), .err_n(err_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ones(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(v[i]);
        return n;
    endfunction

    // Full combinational check of one mode/data point, pass mode assumed
    task automatic sweep_point(input logic an, input logic bn, input logic [W-1:0] da,
                               input logic [W-1:0] db, input logic p);
        logic         e_aoe, e_boe, e_par, e_err;
        logic [W-1:0] e_aout, e_bout;
        int           cnt;
        @(negedge clk);
        a_drive_n = an; b_drive_n = bn; a_in = da; b_in = db; par_in = p;
        #2;
        e_boe  = (bn == 1'b0);
        e_aoe  = (an == 1'b0) && (bn == 1'b1);
        e_aout = e_aoe ? db : '0;
        e_bout = e_boe ? da : '0;
        if (!e_boe)          e_par = 1'b0;
        else if (an == 1'b1) e_par = (ones(da) % 2 == 0);
        else                 e_par = (ones(da) % 2 == 1);
        cnt   = e_boe ? ones(da) + int'(e_par) : ones(db) + int'(p);
        e_err = (cnt % 2 == 1);
        if (an && !bn) begin
            check("R1 b_out", b_out, e_bout); check("R1 par_out", par_out, e_par);
            check("R1 oe", {a_oe, b_oe, par_oe}, {e_aoe, e_boe, e_boe});
        end else if (!an && bn) begin
            check("R2 a_out", a_out, e_aout); check("R2 b_out", {b_out, par_out}, '0);
            check("R2 oe", {a_oe, b_oe, par_oe}, {e_aoe, e_boe, e_boe});
        end else if (!an && !bn) begin
            check("R3 b_out", b_out, e_bout); check("R3 par_out", par_out, e_par);
            check("R3 oe", {a_oe, b_oe, par_oe}, {e_aoe, e_boe, e_boe});
        end else begin
            check("R4 outs", {a_out, b_out, par_out}, '0);
            check("R4 oe", {a_oe, b_oe, par_oe}, 3'b000);
        end
        check("R5 err_n pass", err_n, e_err);
    endtask

    initial begin
        rst_n = 1'b0; a_drive_n = 1'b1; b_drive_n = 1'b1;
        flag_hold = 1'b1; flag_clr_n = 1'b1;
        a_in = '0; b_in = '0; par_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R9 err_n after reset", err_n, 1'b1);
        check("R4 oe after reset", {a_oe, b_oe, par_oe}, 3'b000);

        // Sweep every mode over all data values, random parity corruption
        flag_hold = 1'b0;
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 256; d++) begin
                sweep_point(m[1], m[0], W'(d), W'(d ^ $urandom), 1'(($urandom)));
            end
        end

        // Sample a failing check, then hold it
        @(negedge clk);
        a_drive_n = 1'b0; b_drive_n = 1'b1; flag_hold = 1'b0;
        b_in = 8'h03; par_in = 1'b0;
        #2 check("R5 pass of error", err_n, 1'b0);
        @(negedge clk);
        flag_hold = 1'b1; b_in = 8'h07;
        #2 check("R7 held fault, check good", err_n, 1'b0);
        @(negedge clk);
        #2 check("R7 held fault second cycle", err_n, 1'b0);
        // Clear overrides hold
        @(negedge clk);
        flag_clr_n = 1'b0;
        #2 check("R6 clear forces high", err_n, 1'b1);
        @(negedge clk);
        flag_clr_n = 1'b1; b_in = 8'h03;
        #2 check("R6 register cleared", err_n, 1'b1);
        @(negedge clk);
        #2 check("R7 held clean, check bad", err_n, 1'b1);
        // Sample fault, store it
        @(negedge clk);
        flag_hold = 1'b0;
        #2 check("R5 pass bad", err_n, 1'b0);
        @(negedge clk);
        flag_hold = 1'b1; b_in = 8'h07;
        #2 check("R8 sampled fault kept", err_n, 1'b0);
        // Sample clean, store it
        @(negedge clk);
        flag_hold = 1'b0;
        #2 check("R5 pass good", err_n, 1'b1);
        @(negedge clk);
        flag_hold = 1'b1; b_in = 8'h03;
        #2 check("R8 sampled clean kept", err_n, 1'b1);
        // Clear in pass mode with a bad check
        @(negedge clk);
        flag_hold = 1'b0; flag_clr_n = 1'b0;
        #2 check("R6 clear in pass", err_n, 1'b1);
        // Diagnostic mode shows error through pass
        @(negedge clk);
        flag_clr_n = 1'b1; a_drive_n = 1'b0; b_drive_n = 1'b0; a_in = 8'h5A;
        #2 check("R3 diag error flag", err_n, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule